// File: doc/BRIEF.md
# Configurable SPI Target Serial Engine

This block is the bit-level core of an SPI target. It watches an external serial clock and an active-low select, samples the incoming data line and drives the outgoing data line. A control word sets the clock phase and polarity, the word size (4, 8 or 16 bits), the bit order and the transfer direction. Transmit words come from an internal TX FIFO, and received words go into an internal RX FIFO. All serial inputs pass through synchronizers into the system clock domain, so the serial clock must run well below the system clock.

A frame counter, loaded with the word count minus one, ends the transfer once that many words have passed. After that the engine ignores the bus until `enable_i` is lowered and raised again. Status outputs give a busy flag, a transmit-path busy flag and the synchronized level of the select line. With the select line, software can confirm that the master has released the bus before it arms the next transfer.

Top module: `spi_tgt_engine`

## Requirements
- R1: After reset `miso_o`, `busy_o`, `tx_busy_o` and `rx_valid_o` are 0, while `tx_ready_o` and `cs_level_o` are 1.
- R2: Control bits 1:0 select the word size: 0 gives 4 bits, 1 gives 8 bits and 2 gives 16 bits. Each received word is written to the RX FIFO right-aligned and zero-extended.
- R3: Control bit 6 is the clock phase and bit 7 is the idle clock level. With phase 0, data is sampled on the first clock edge of each bit. With phase 1, data is sampled on the second edge. All four combinations transfer correctly.
- R4: Control bit 12 selects the bit order: 0 shifts the most significant bit first and 1 shifts the least significant bit first. The order applies to both directions.
- R5: Control bits 19:18 select the direction: 0 is full duplex, 1 is transmit-only and 2 is receive-only. In transmit-only mode no word reaches the RX FIFO. In receive-only mode `miso_o` stays 0 and the TX FIFO is left untouched.
- R6: Control bit 20 must be 1 for target operation. While it is 0 the engine ignores the bus: `miso_o` and `busy_o` stay 0, no RX word is written and no TX word is consumed.
- R7: Once `len_m1_i`+1 words have completed, `busy_o` drops and further clocks move no data and consume no TX word. Lowering and raising `enable_i` re-arms the counter.
- R8: Releasing select in mid-word discards the partial word and resets the bit position. The TX word that had started is dropped, and the next assertion begins a fresh word.
- R9: If the TX FIFO is empty when a word starts, the engine shifts out zeros for that word and consumes nothing.
- R10: `cs_level_o` follows `cs_ni` with exactly two system clock cycles of delay.
- R11: `busy_o` is 1 while the engine is armed, unfinished and selected. `tx_busy_o` is 1 from the first sampled bit of a transmitted word until its last bit.
- R12: A TX word is consumed only at the first sampled bit of its word. A word that is queued but not yet started carries intact across select frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Arms the engine; low clears the frame counter |
| ctrl_i | input | 32 | Control word (size, clock mode, order, direction, target) |
| len_m1_i | input | 16 | Words per transfer minus one |
| sclk_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Select from master, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| tx_valid_i | input | 1 | TX FIFO write strobe |
| tx_data_i | input | 16 | TX FIFO write data |
| tx_ready_o | output | 1 | TX FIFO has space |
| rx_valid_o | output | 1 | RX FIFO holds a word |
| rx_data_o | output | 16 | RX FIFO head word |
| rx_ready_i | input | 1 | RX FIFO read strobe |
| busy_o | output | 1 | Transfer in progress |
| tx_busy_o | output | 1 | Transmit word in flight |
| cs_level_o | output | 1 | Synchronized select level |

## Verification
A bit counter that drifts shows up at once as rotated RX words and as MISO bits landing at the wrong positions, both visible in the first word after the fault. A TX pop at the wrong moment, either at select assertion or in a mode that does not transmit, shifts the whole transmit sequence by one word. That slip is seen in the first frame that follows, often several frames after its cause. A frame counter that stops late or early changes `busy_o` and the MISO value of the word past the limit, in the same frame.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int MAX_W     = 16;
  localparam int BW        = $clog2(MAX_W);
  localparam int DFS_LSB   = 0;
  localparam int CKM_LSB   = 6;
  localparam int ORDER_BIT = 12;
  localparam int XFER_LSB  = 18;
  localparam int TGT_BIT   = 20;

  typedef enum logic [1:0] {
    XFER_DUPLEX  = 2'd0,
    XFER_TX_ONLY = 2'd1,
    XFER_RX_ONLY = 2'd2,
    XFER_RSVD    = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic [1:0] dfs;
    logic       cpha;
    logic       cpol;
    logic       lsb_first;
    xfer_mode_e xfer;
    logic       target;
  } cfg_t;

  function automatic cfg_t decode_ctrl(input logic [31:0] c);
    cfg_t r;
    r.dfs       = c[DFS_LSB +: 2];
    r.cpha      = c[CKM_LSB];
    r.cpol      = c[CKM_LSB + 1];
    r.lsb_first = c[ORDER_BIT];
    r.xfer      = xfer_mode_e'(c[XFER_LSB +: 2]);
    r.target    = c[TGT_BIT];
    return r;
  endfunction

  function automatic logic [4:0] word_bits(input logic [1:0] dfs);
    case (dfs)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/spi_tgt_fifo.sv
module spi_tgt_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  assign empty_o = (wptr == rptr);
  assign full_o  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign head_o  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_i && !full_o) wptr <= wptr + 1'b1;
      if (pop_i && !empty_o) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wptr[AW-1:0]] <= data_i;
  end

  // R9
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
  import spi_tgt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             run_i,
  input  logic [15:0]      len_m1_i,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             mosi_i,
  output logic             miso_o,
  input  logic [MAX_W-1:0] tx_head_i,
  input  logic             tx_empty_i,
  output logic             tx_pop_o,
  output logic [MAX_W-1:0] rx_word_o,
  output logic             rx_push_o,
  output logic             busy_o,
  output logic             tx_busy_o,
  output logic             cs_level_o
);
  logic [2:0]       sclk_s;
  logic [1:0]       cs_s, mosi_s;
  logic [BW-1:0]    bit_cnt, out_idx;
  logic [15:0]      words;
  logic             done;
  logic [MAX_W-1:0] tx_word, rx_sr, rx_next, cur_word;
  logic [4:0]       width;
  logic             rise, fall, smp_ev, drv_ev, active, last, tx_en, rx_en;

  function automatic logic [BW-1:0] pos_of(input logic [BW-1:0] k, input logic [4:0] w,
                                           input logic lsb);
    logic [BW-1:0] top;
    top = BW'(w - 5'd1);
    return lsb ? k : top - k;
  endfunction

  assign rise   = (sclk_s[2:1] == 2'b01);
  assign fall   = (sclk_s[2:1] == 2'b10);
  // leading edge leaves the idle level; phase picks which edge samples
  assign smp_ev = cfg_i.cpha ? (cfg_i.cpol ? rise : fall) : (cfg_i.cpol ? fall : rise);
  assign drv_ev = cfg_i.cpha ? (cfg_i.cpol ? fall : rise) : (cfg_i.cpol ? rise : fall);

  assign width  = word_bits(cfg_i.dfs);
  assign last   = ({1'b0, bit_cnt} == width - 5'd1);
  assign tx_en  = (cfg_i.xfer != XFER_RX_ONLY);
  assign rx_en  = (cfg_i.xfer != XFER_TX_ONLY);
  assign active = run_i && cfg_i.target && !done && !cs_s[1];

  // before the first sample the word is taken from the FIFO head without popping
  assign cur_word = (bit_cnt == '0) ? (tx_empty_i ? '0 : tx_head_i) : tx_word;

  always_comb begin
    rx_next = (bit_cnt == '0) ? '0 : rx_sr;
    rx_next[pos_of(bit_cnt, width, cfg_i.lsb_first)] = mosi_s[1];
  end

  assign miso_o     = active && tx_en && cur_word[pos_of(out_idx, width, cfg_i.lsb_first)];
  assign tx_pop_o   = active && smp_ev && (bit_cnt == '0) && tx_en && !tx_empty_i;
  assign rx_push_o  = active && smp_ev && last && rx_en;
  assign rx_word_o  = rx_next;
  assign busy_o     = active;
  assign tx_busy_o  = active && tx_en && (bit_cnt != '0);
  assign cs_level_o = cs_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s  <= '0;
      cs_s    <= 2'b11;
      mosi_s  <= '0;
      bit_cnt <= '0;
      out_idx <= '0;
      words   <= '0;
      done    <= 1'b0;
      tx_word <= '0;
      rx_sr   <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[0], cs_ni};
      mosi_s <= {mosi_s[0], mosi_i};
      if (!run_i) begin
        words <= '0;
        done  <= 1'b0;
      end
      if (!active) begin
        bit_cnt <= '0;
        out_idx <= '0;
      end else begin
        if (drv_ev) out_idx <= bit_cnt;
        if (smp_ev) begin
          rx_sr <= rx_next;
          if (bit_cnt == '0) tx_word <= cur_word;
          if (last) begin
            bit_cnt <= '0;
            words   <= words + 16'd1;
            if (words == len_m1_i) done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R8
  cs_release_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s[1] |=> (bit_cnt == '0));
  // R2
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_i) |-> ({1'b0, bit_cnt} < width));
  // R7
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && run_i) |=> $stable(words));
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
  import spi_tgt_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic [31:0] ctrl_i,
  input  logic [15:0] len_m1_i,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  input  logic        tx_valid_i,
  input  logic [15:0] tx_data_i,
  output logic        tx_ready_o,
  output logic        rx_valid_o,
  output logic [15:0] rx_data_o,
  input  logic        rx_ready_i,
  output logic        busy_o,
  output logic        tx_busy_o,
  output logic        cs_level_o
);
  cfg_t             cfg;
  logic [MAX_W-1:0] tx_head, rx_word;
  logic             tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
  logic             unused_ctrl;

  assign cfg         = decode_ctrl(ctrl_i);
  assign unused_ctrl = ^{ctrl_i[31:21], ctrl_i[17:13], ctrl_i[11:8], ctrl_i[5:2], rx_full};

  assign tx_ready_o = !tx_full;
  assign rx_valid_o = !rx_empty;

  spi_tgt_fifo #(.W(MAX_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .head_o  (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  // a full RX FIFO drops new words
  spi_tgt_fifo #(.W(MAX_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_word),
    .pop_i   (rx_ready_i && !rx_empty),
    .head_o  (rx_data_o),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  spi_tgt_shifter u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .run_i      (enable_i),
    .len_m1_i   (len_m1_i),
    .sclk_i     (sclk_i),
    .cs_ni      (cs_ni),
    .mosi_i     (mosi_i),
    .miso_o     (miso_o),
    .tx_head_i  (tx_head),
    .tx_empty_i (tx_empty),
    .tx_pop_o   (tx_pop),
    .rx_word_o  (rx_word),
    .rx_push_o  (rx_push),
    .busy_o     (busy_o),
    .tx_busy_o  (tx_busy_o),
    .cs_level_o (cs_level_o)
  );

  // R5
  rx_only_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.xfer == XFER_RX_ONLY) |-> !tx_pop);
  // R5
  tx_only_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.xfer == XFER_TX_ONLY) |-> !rx_push);
  // R6
  target_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.target |-> (!rx_push && !tx_pop && !busy_o));
endmodule

// File: tb/tb_spi_tgt_engine.sv
module tb_spi_tgt_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] ctrl = '0;
  logic [15:0] len_m1 = 16'hFFFF;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, tx_ready, rx_valid, rx_ready = 1'b0, busy, tx_busy, cs_level;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0, rx_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  int txq[$];
  int rxq[$];
  int mwords = 0;
  logic m_cpol, m_cpha, m_lsb, m_tgt;
  logic [1:0] m_dfs, m_xm;
  logic [1:0] cs_hist;

  spi_tgt_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ctrl_i(ctrl), .len_m1_i(len_m1),
    .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ready_i(rx_ready),
    .busy_o(busy), .tx_busy_o(tx_busy), .cs_level_o(cs_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R10: reference select history, compared every clock
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cs_hist <= 2'b11;
    else cs_hist <= {cs_hist[0], cs_n};
  always @(negedge clk)
    if (rst_n && !finished) check(cs_level === cs_hist[1], "R10 cs_level", cs_level, cs_hist[1]);

  function automatic int wbits();
    return (m_dfs == 2'd0) ? 4 : (m_dfs == 2'd1) ? 8 : 16;
  endfunction
  function automatic logic [15:0] wmask();
    return 16'((32'd1 << wbits()) - 1);
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic cpol, input logic cpha, input logic [1:0] dfs, input logic lsb,
                       input logic [1:0] xm, input logic tgt, input logic [15:0] len);
    @(negedge clk);
    enable = 1'b0;
    m_cpol = cpol; m_cpha = cpha; m_dfs = dfs; m_lsb = lsb; m_xm = xm; m_tgt = tgt;
    ctrl = (32'(dfs) << 0) | (32'(cpha) << 6) | (32'(cpol) << 7) | (32'(lsb) << 12) |
           (32'(xm) << 18) | (32'(tgt) << 20);
    len_m1 = len;
    sclk = cpol;
    mwords = 0;
    waitn(3);
    enable = 1'b1;
    waitn(2);
  endtask

  task automatic push_tx(input logic [15:0] w);
    @(negedge clk);
    check(tx_ready === 1'b1, "R12 tx space", tx_ready, 1);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
    txq.push_back(int'(w));
  endtask

  task automatic master_word(input logic [15:0] w, input int nbits, output logic [15:0] got,
                             output logic busy_mid);
    got = '0;
    busy_mid = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      int p;
      p = m_lsb ? k : wbits() - 1 - k;
      if (!m_cpha) begin
        mosi = w[p];
        waitn(HALF);
        got[p] = miso;
        if (k == 1) busy_mid = tx_busy;
        sclk = ~m_cpol;
        waitn(HALF);
        sclk = m_cpol;
      end else begin
        sclk = ~m_cpol;
        mosi = w[p];
        waitn(HALF);
        got[p] = miso;
        if (k == 1) busy_mid = tx_busy;
        sclk = m_cpol;
        waitn(HALF);
      end
    end
  endtask

  task automatic do_frame(input int n, input logic [15:0] seed, input string req);
    logic [15:0] got, w, exp;
    logic bm;
    bit elig;
    @(negedge clk);
    sclk = m_cpol;
    cs_n = 1'b0;
    waitn(HALF);
    for (int k = 0; k < n; k++) begin
      w = seed ^ 16'(k * 16'h2B6D);
      elig = m_tgt && (mwords <= int'(len_m1));
      check(busy === elig, "R11 busy before word", busy, elig);
      exp = '0;
      if (elig && m_xm != 2'd2 && txq.size() > 0) exp = 16'(txq.pop_front()) & wmask();
      if (elig && m_xm != 2'd1) rxq.push_back(int'(w & wmask()));
      if (elig) mwords++;
      master_word(w, wbits(), got, bm);
      check(got === exp, req, got, exp);
      check(bm === (elig && m_xm != 2'd2), "R11 tx_busy mid-word", bm, elig && m_xm != 2'd2);
    end
    elig = m_tgt && (mwords <= int'(len_m1));
    check(busy === elig, "R7 R11 busy after words", busy, elig);
    waitn(HALF);
    cs_n = 1'b1;
    waitn(2 * HALF);
    check(busy === 1'b0, "R11 busy idle", busy, 0);
  endtask

  task automatic drain(input string req);
    while (rxq.size() > 0) begin
      logic [15:0] e;
      e = 16'(rxq.pop_front());
      check(rx_valid === 1'b1, req, rx_valid, 1);
      check(rx_data === e, req, rx_data, e);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    check(rx_valid === 1'b0, {req, " no extra rx"}, rx_valid, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] g;
    logic bm;
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(miso === 1'b0 && busy === 1'b0 && tx_busy === 1'b0, "R1 outputs idle",
          {miso, busy, tx_busy}, 0);
    check(rx_valid === 1'b0 && tx_ready === 1'b1 && cs_level === 1'b1, "R1 fifo/cs",
          {rx_valid, tx_ready, cs_level}, 3'b011);

    // R2 R3 mode 0, 8-bit, MSB first
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'hFFFF);
    push_tx(16'h00A5); push_tx(16'h003C); push_tx(16'h00F0);
    do_frame(3, 16'h1234, "R2 R3 mode0 8b");
    drain("R2 rx 8b");

    // R4 R3 mode 3, 16-bit, LSB first
    setup(1, 1, 2'd2, 1, 2'd0, 1, 16'hFFFF);
    push_tx(16'hBEEF); push_tx(16'h8001);
    do_frame(2, 16'hC35A, "R4 R3 mode3 16b lsb");
    drain("R4 rx 16b");

    // R2 R3 mode 1, 4-bit
    setup(0, 1, 2'd0, 0, 2'd0, 1, 16'hFFFF);
    push_tx(16'hFFF9); push_tx(16'h0006);
    do_frame(2, 16'h000D, "R2 R3 mode1 4b");
    drain("R2 rx 4b");

    // R3 R4 mode 2, 8-bit LSB first
    setup(1, 0, 2'd1, 1, 2'd0, 1, 16'hFFFF);
    push_tx(16'h0081);
    do_frame(1, 16'h00C2, "R3 R4 mode2 8b lsb");
    drain("R4 rx mode2");

    // R9 empty TX FIFO shifts zeros
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'hFFFF);
    do_frame(2, 16'h00FF, "R9 empty tx zeros");
    drain("R9 rx");

    // R5 receive-only, then R12 word carried to next frame
    push_tx(16'h005B);
    setup(0, 0, 2'd1, 0, 2'd2, 1, 16'hFFFF);
    do_frame(2, 16'h0077, "R5 rx-only miso zero");
    drain("R5 rx-only rx");
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'hFFFF);
    do_frame(1, 16'h0011, "R12 R5 tx word kept");
    drain("R12 rx");

    // R5 transmit-only
    setup(0, 1, 2'd1, 0, 2'd1, 1, 16'hFFFF);
    push_tx(16'h0096); push_tx(16'h0069);
    do_frame(2, 16'h00AA, "R5 tx-only miso");
    drain("R5 tx-only no rx");

    // R6 target bit clear
    push_tx(16'h00E7);
    setup(0, 0, 2'd1, 0, 2'd0, 0, 16'hFFFF);
    do_frame(2, 16'h0042, "R6 target off");
    drain("R6 no rx");
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'hFFFF);
    do_frame(1, 16'h0024, "R6 R12 tx untouched");
    drain("R6 rx after");

    // R7 frame length limit and re-arm
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'd1);
    push_tx(16'h0031); push_tx(16'h0032); push_tx(16'h0033);
    do_frame(3, 16'h0050, "R7 limit");
    drain("R7 rx limit");
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'd1);
    do_frame(1, 16'h0060, "R7 re-arm");
    drain("R7 rx re-arm");

    // R8 mid-word release
    setup(0, 0, 2'd1, 0, 2'd0, 1, 16'hFFFF);
    push_tx(16'h00C1); push_tx(16'h003E);
    @(negedge clk);
    cs_n = 1'b0;
    waitn(HALF);
    master_word(16'h00FF, 3, g, bm);
    waitn(HALF);
    cs_n = 1'b1;
    void'(txq.pop_front());
    waitn(2 * HALF);
    check(tx_busy === 1'b0, "R8 tx_busy cleared", tx_busy, 0);
    do_frame(1, 16'h0099, "R8 fresh word");
    drain("R8 partial discarded");

    finish_run();
  end
endmodule